// File: doc/BRIEF.md
# Scoreboard Issue Stage

This stage sits between the per-warp instruction buffers and the operand-collection lanes of a multi-warp core. Each cycle every issue lane is bound to one warp buffer. The binding starts at a rotating base: lane `i` serves buffer `(base + i) mod NUM_WARPS`, and the base moves forward by the issue width after every clock. A lane pops the head instruction of its buffer and forwards it to the operand stage only when two conditions hold. None of the instruction's registers (two sources and one destination) may be pending in that warp's scoreboard. The lane's operand register must also be able to accept a new entry.

An instruction that writes back reserves its destination register when it issues. The scoreboard records which functional-unit class will produce that register. The register is freed by the commit port, but only when the committing instruction closes its packet and writes back. When a lane is blocked by the scoreboard, it adds to a total stall counter. It also adds to one per-class counter for each distinct pending register it ran into, chosen by that register's recorded producer class. Issued and committed instruction counts are kept, and a busy flag shows whether they differ.

Each lane's decision is an enumerated state, evaluated in priority order every cycle:
- `LANE_IDLE`: the buffer is empty.
- `LANE_HAZARD`: the buffer has a head but one of its registers is pending.
- `LANE_HELD`: there is no hazard but the operand register is full and not being drained.
- `LANE_ISSUE`: none of the above applies.

A lane moves between these states freely from one cycle to the next, with no memory of its previous state.

Top module: `isq_issue_stage`

## Requirements
- R1: After reset every `opd_valid` bit is 0, all counters read 0, `core_busy` is 0 and no register is pending.
- R2: The base is 0 after reset and advances by ISSUE_W modulo NUM_WARPS on every clock. Lane i examines buffer (base+i) mod NUM_WARPS, and only examined buffers can pop, at most ISSUE_W per cycle.
- R3: An empty buffer leaves its lane idle; the other lanes still issue, and a buffer never pops while its valid bit is low.
- R4: A head whose rs1, rs2 or rd is pending in its own warp does not pop, and `stall_total` rises by 1 for each lane so blocked in a cycle.
- R5: For a blocked lane, each distinct pending register among rs1, rs2 and rd adds 1 to the `stall_unit` slice of the class that reserved it. Slice c is bits [c*CNT_W +: CNT_W], with class codes 0 ALU, 1 FPU, 2 LSU, 3 SFU.
- R6: Only an issued instruction with its writeback bit set reserves its rd; an instruction without it leaves every register free.
- R7: A commit frees its register only when `cmt_valid`, `cmt_eop` and `cmt_wb` are all 1; a commit missing either flag leaves the register pending.
- R8: An instruction popped in cycle n appears on its lane's operand outputs in cycle n+1, with the warp number and its fields. Each field of lane l is packed at [l*width +: width].
- R9: While a lane's `opd_valid` is 1 and its `opd_ready` is 0, that lane pops nothing, does not count a stall and holds its operand outputs.
- R10: `issued_cnt` rises by the number of pops per cycle, `committed_cnt` by 1 per commit with `cmt_valid` and `cmt_eop`, and `core_busy` is 1 exactly when the two differ.
- R11: Pending state is per warp and per register index: the 6-bit index gives 32 integer registers (bit 5 = 0) and 32 floating-point registers (bit 5 = 1). The same index in another warp, or the other file's register with the same low bits, does not conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ibuf_valid | input | NUM_WARPS | Buffer w holds a head instruction |
| ibuf_wb | input | NUM_WARPS | Head writes back its rd |
| ibuf_unit | input | NUM_WARPS*2 | Head functional-unit class |
| ibuf_rd | input | NUM_WARPS*REG_W | Head destination register |
| ibuf_rs1 | input | NUM_WARPS*REG_W | Head first source register |
| ibuf_rs2 | input | NUM_WARPS*REG_W | Head second source register |
| ibuf_pop | output | NUM_WARPS | Head of buffer w is taken this cycle |
| opd_ready | input | ISSUE_W | Operand lane drains its entry |
| opd_valid | output | ISSUE_W | Operand lane holds an instruction |
| opd_warp | output | ISSUE_W*WARP_W | Warp of the lane's instruction |
| opd_wb | output | ISSUE_W | Writeback bit |
| opd_unit | output | ISSUE_W*2 | Unit class |
| opd_rd | output | ISSUE_W*REG_W | Destination register |
| opd_rs1 | output | ISSUE_W*REG_W | First source register |
| opd_rs2 | output | ISSUE_W*REG_W | Second source register |
| cmt_valid | input | 1 | Commit event |
| cmt_warp | input | WARP_W | Committing warp |
| cmt_rd | input | REG_W | Committing destination register |
| cmt_wb | input | 1 | Committing instruction writes back |
| cmt_eop | input | 1 | Committing instruction ends its packet |
| stall_total | output | CNT_W | Lane-cycles blocked by the scoreboard |
| stall_unit | output | 4*CNT_W | Per-class conflict counts |
| issued_cnt | output | CNT_W | Instructions issued |
| committed_cnt | output | CNT_W | End-of-packet commits |
| core_busy | output | 1 | Issued and committed counts differ |

## Verification
The bench steers the rotating base to chosen values and places hazards on each lane. A rotation error would pop the wrong buffers and send warps to the wrong lanes. Repeated sources naming the same pending register must not count twice, and a design that skips the dedupe would inflate a class counter. Commits missing only the end-of-packet bit or only the writeback bit must leave a register pending, since freeing on either alone would let a dependent issue early. An unready operand lane must hold its entry without popping or counting a stall. Losing that would overwrite the held instruction or inflate `stall_total`.

// File: rtl/isq_pkg.sv
package isq_pkg;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = 2;
    localparam int NUM_SLOTS = 3;   // 0: rs1, 1: rs2, 2: rd

    typedef enum logic [UNIT_W-1:0] {
        UNIT_ALU = 2'd0,
        UNIT_FPU = 2'd1,
        UNIT_LSU = 2'd2,
        UNIT_SFU = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        LANE_IDLE,
        LANE_ISSUE,
        LANE_HAZARD,
        LANE_HELD
    } lane_st_e;
endpackage

// File: rtl/isq_scoreboard.sv
module isq_scoreboard
    import isq_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int LANES     = 2,
    parameter int REG_W     = 6,
    localparam int WARP_W   = $clog2(NUM_WARPS),
    localparam int NUM_REGS = 1 << REG_W
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [LANES-1:0][WARP_W-1:0]                q_warp,
    input  logic [LANES-1:0][NUM_SLOTS-1:0][REG_W-1:0]  q_reg,
    output logic [LANES-1:0][NUM_SLOTS-1:0]             q_hit,
    output logic [LANES-1:0][NUM_SLOTS-1:0][UNIT_W-1:0] q_unit,
    input  logic [LANES-1:0]                            rsv_en,
    input  logic [LANES-1:0][UNIT_W-1:0]                rsv_unit,
    input  logic                                        rel_en,
    input  logic [WARP_W-1:0]                           rel_warp,
    input  logic [REG_W-1:0]                            rel_reg
);
    logic [NUM_WARPS-1:0][NUM_REGS-1:0]             pend_q;
    logic [NUM_WARPS-1:0][NUM_REGS-1:0][UNIT_W-1:0] unit_q;

    // Release first, reservations after: a reserve of the same entry wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            unit_q <= '0;
        end else begin
            if (rel_en)
                pend_q[rel_warp][rel_reg] <= 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (rsv_en[l]) begin
                    pend_q[q_warp[l]][q_reg[l][2]] <= 1'b1;
                    unit_q[q_warp[l]][q_reg[l][2]] <= rsv_unit[l];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                q_hit[l][s]  = pend_q[q_warp[l]][q_reg[l][s]];
                q_unit[l][s] = unit_q[q_warp[l]][q_reg[l][s]];
            end
        end
    end
endmodule

// File: rtl/isq_lane.sv
module isq_lane
    import isq_pkg::*;
#(
    parameter int REG_W = 6
) (
    input  logic                                head_valid,
    input  logic                                lane_free,
    input  logic [NUM_SLOTS-1:0]                hit,
    input  logic [NUM_SLOTS-1:0][UNIT_W-1:0]    hit_unit,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0]     regs,
    output logic                                issue,
    output logic                                hazard,
    output logic [NUM_UNITS-1:0][1:0]           unit_inc
);
    lane_st_e             st;
    logic [NUM_SLOTS-1:0] counted;

    always_comb begin
        if (!head_valid)
            st = LANE_IDLE;
        else if (|hit)
            st = LANE_HAZARD;
        else if (!lane_free)
            st = LANE_HELD;
        else
            st = LANE_ISSUE;
    end

    // A register named by more than one slot is counted once.
    always_comb begin
        counted[0] = hit[0];
        counted[1] = hit[1] && (regs[1] != regs[0]);
        counted[2] = hit[2] && (regs[2] != regs[0]) && (regs[2] != regs[1]);
    end

    always_comb begin
        issue    = 1'b0;
        hazard   = 1'b0;
        unit_inc = '0;
        unique case (st)
            LANE_IDLE:  ;
            LANE_HELD:  ;
            LANE_ISSUE: issue = 1'b1;
            LANE_HAZARD: begin
                hazard = 1'b1;
                for (int s = 0; s < NUM_SLOTS; s++)
                    if (counted[s])
                        unit_inc[hit_unit[s]] = unit_inc[hit_unit[s]] + 2'd1;
            end
        endcase
    end
endmodule

// File: rtl/isq_counters.sv
module isq_counters
    import isq_pkg::*;
#(
    parameter int LANES = 2,
    parameter int CNT_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [LANES-1:0]                       hazard,
    input  logic [LANES-1:0][NUM_UNITS-1:0][1:0]   unit_inc,
    input  logic [LANES-1:0]                       issue,
    input  logic                                   commit_eop,
    output logic [CNT_W-1:0]                       stall_total,
    output logic [NUM_UNITS-1:0][CNT_W-1:0]        stall_unit,
    output logic [CNT_W-1:0]                       issued,
    output logic [CNT_W-1:0]                       committed
);
    logic [CNT_W-1:0]                n_haz, n_iss;
    logic [NUM_UNITS-1:0][CNT_W-1:0] n_unit;

    always_comb begin
        n_haz  = '0;
        n_iss  = '0;
        n_unit = '0;
        for (int l = 0; l < LANES; l++) begin
            n_haz = n_haz + CNT_W'(hazard[l]);
            n_iss = n_iss + CNT_W'(issue[l]);
            for (int u = 0; u < NUM_UNITS; u++)
                n_unit[u] = n_unit[u] + CNT_W'(unit_inc[l][u]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_total <= '0;
            stall_unit  <= '0;
            issued      <= '0;
            committed   <= '0;
        end else begin
            stall_total <= stall_total + n_haz;
            issued      <= issued + n_iss;
            committed   <= committed + CNT_W'(commit_eop);
            for (int u = 0; u < NUM_UNITS; u++)
                stall_unit[u] <= stall_unit[u] + n_unit[u];
        end
    end
endmodule

// File: rtl/isq_issue_stage.sv
module isq_issue_stage
    import isq_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int ISSUE_W   = 2,
    parameter int REG_W     = 6,
    parameter int CNT_W     = 16,
    localparam int WARP_W   = $clog2(NUM_WARPS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WARPS-1:0]          ibuf_valid,
    input  logic [NUM_WARPS-1:0]          ibuf_wb,
    input  logic [NUM_WARPS*2-1:0]        ibuf_unit,
    input  logic [NUM_WARPS*REG_W-1:0]    ibuf_rd,
    input  logic [NUM_WARPS*REG_W-1:0]    ibuf_rs1,
    input  logic [NUM_WARPS*REG_W-1:0]    ibuf_rs2,
    output logic [NUM_WARPS-1:0]          ibuf_pop,
    input  logic [ISSUE_W-1:0]            opd_ready,
    output logic [ISSUE_W-1:0]            opd_valid,
    output logic [ISSUE_W*WARP_W-1:0]     opd_warp,
    output logic [ISSUE_W-1:0]            opd_wb,
    output logic [ISSUE_W*2-1:0]          opd_unit,
    output logic [ISSUE_W*REG_W-1:0]      opd_rd,
    output logic [ISSUE_W*REG_W-1:0]      opd_rs1,
    output logic [ISSUE_W*REG_W-1:0]      opd_rs2,
    input  logic                          cmt_valid,
    input  logic [WARP_W-1:0]             cmt_warp,
    input  logic [REG_W-1:0]              cmt_rd,
    input  logic                          cmt_wb,
    input  logic                          cmt_eop,
    output logic [CNT_W-1:0]              stall_total,
    output logic [4*CNT_W-1:0]            stall_unit,
    output logic [CNT_W-1:0]              issued_cnt,
    output logic [CNT_W-1:0]              committed_cnt,
    output logic                          core_busy
);
    localparam logic [WARP_W:0] NW_EXT   = (WARP_W+1)'(NUM_WARPS);
    localparam logic [WARP_W:0] STEP_EXT = (WARP_W+1)'(ISSUE_W % NUM_WARPS);

    logic [WARP_W-1:0]                           base_q;
    logic [WARP_W:0]                             base_sum;
    logic [ISSUE_W-1:0][WARP_W:0]                wsum;
    logic [ISSUE_W-1:0][WARP_W-1:0]              lane_warp;
    logic [ISSUE_W-1:0][NUM_SLOTS-1:0][REG_W-1:0] lane_reg;
    logic [ISSUE_W-1:0][UNIT_W-1:0]              lane_unit;
    logic [ISSUE_W-1:0]                          head_valid, head_wb, lane_free;
    logic [ISSUE_W-1:0]                          lane_issue, lane_hazard, rsv_en;
    logic [ISSUE_W-1:0][NUM_UNITS-1:0][1:0]      lane_unit_inc;
    logic [ISSUE_W-1:0][NUM_SLOTS-1:0]           sb_hit;
    logic [ISSUE_W-1:0][NUM_SLOTS-1:0][UNIT_W-1:0] sb_unit;
    logic [NUM_UNITS-1:0][CNT_W-1:0]             stall_unit_w;

    logic [ISSUE_W-1:0]                          ov_q, owb_q;
    logic [ISSUE_W-1:0][WARP_W-1:0]              ow_q;
    logic [ISSUE_W-1:0][UNIT_W-1:0]              ou_q;
    logic [ISSUE_W-1:0][REG_W-1:0]               ord_q, ors1_q, ors2_q;

    // Rotating base, advanced by the issue width each clock.
    always_comb begin
        base_sum = {1'b0, base_q} + STEP_EXT;
        if (base_sum >= NW_EXT)
            base_sum = base_sum - NW_EXT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_sum[WARP_W-1:0];
    end

    // Lane to buffer binding and head selection.
    always_comb begin
        for (int l = 0; l < ISSUE_W; l++) begin
            wsum[l] = {1'b0, base_q} + (WARP_W+1)'(l);
            if (wsum[l] >= NW_EXT)
                wsum[l] = wsum[l] - NW_EXT;
            lane_warp[l]   = wsum[l][WARP_W-1:0];
            head_valid[l]  = ibuf_valid[lane_warp[l]];
            head_wb[l]     = ibuf_wb[lane_warp[l]];
            lane_unit[l]   = ibuf_unit[lane_warp[l]*2 +: 2];
            lane_reg[l][0] = ibuf_rs1[lane_warp[l]*REG_W +: REG_W];
            lane_reg[l][1] = ibuf_rs2[lane_warp[l]*REG_W +: REG_W];
            lane_reg[l][2] = ibuf_rd[lane_warp[l]*REG_W +: REG_W];
            lane_free[l]   = !ov_q[l] || opd_ready[l];
            rsv_en[l]      = lane_issue[l] && head_wb[l];
        end
    end

    isq_scoreboard #(.NUM_WARPS(NUM_WARPS), .LANES(ISSUE_W), .REG_W(REG_W)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_warp   (lane_warp),
        .q_reg    (lane_reg),
        .q_hit    (sb_hit),
        .q_unit   (sb_unit),
        .rsv_en   (rsv_en),
        .rsv_unit (lane_unit),
        .rel_en   (cmt_valid && cmt_eop && cmt_wb),
        .rel_warp (cmt_warp),
        .rel_reg  (cmt_rd)
    );

    for (genvar g = 0; g < ISSUE_W; g++) begin : g_lane
        isq_lane #(.REG_W(REG_W)) u_lane (
            .head_valid (head_valid[g]),
            .lane_free  (lane_free[g]),
            .hit        (sb_hit[g]),
            .hit_unit   (sb_unit[g]),
            .regs       (lane_reg[g]),
            .issue      (lane_issue[g]),
            .hazard     (lane_hazard[g]),
            .unit_inc   (lane_unit_inc[g])
        );
    end

    always_comb begin
        ibuf_pop = '0;
        for (int l = 0; l < ISSUE_W; l++)
            if (lane_issue[l])
                ibuf_pop[lane_warp[l]] = 1'b1;
    end

    // One-entry operand register per lane.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q <= '0; owb_q <= '0; ow_q <= '0; ou_q <= '0;
            ord_q <= '0; ors1_q <= '0; ors2_q <= '0;
        end else begin
            for (int l = 0; l < ISSUE_W; l++) begin
                if (lane_issue[l]) begin
                    ov_q[l]   <= 1'b1;
                    owb_q[l]  <= head_wb[l];
                    ow_q[l]   <= lane_warp[l];
                    ou_q[l]   <= lane_unit[l];
                    ors1_q[l] <= lane_reg[l][0];
                    ors2_q[l] <= lane_reg[l][1];
                    ord_q[l]  <= lane_reg[l][2];
                end else if (opd_ready[l]) begin
                    ov_q[l]   <= 1'b0;
                end
            end
        end
    end

    isq_counters #(.LANES(ISSUE_W), .CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hazard      (lane_hazard),
        .unit_inc    (lane_unit_inc),
        .issue       (lane_issue),
        .commit_eop  (cmt_valid && cmt_eop),
        .stall_total (stall_total),
        .stall_unit  (stall_unit_w),
        .issued      (issued_cnt),
        .committed   (committed_cnt)
    );

    assign stall_unit = stall_unit_w;
    assign core_busy  = (issued_cnt != committed_cnt);
    assign opd_valid  = ov_q;
    assign opd_wb     = owb_q;
    assign opd_warp   = ow_q;
    assign opd_unit   = ou_q;
    assign opd_rd     = ord_q;
    assign opd_rs1    = ors1_q;
    assign opd_rs2    = ors2_q;
endmodule

// File: rtl/isq_issue_stage_chk.sv
module isq_issue_stage_chk #(
    parameter int NUM_WARPS = 4,
    parameter int ISSUE_W   = 2,
    parameter int REG_W     = 6,
    parameter int CNT_W     = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_WARPS-1:0]     ibuf_valid,
    input logic [NUM_WARPS-1:0]     ibuf_pop,
    input logic [ISSUE_W-1:0]       opd_ready,
    input logic [ISSUE_W-1:0]       opd_valid,
    input logic [ISSUE_W*REG_W-1:0] opd_rd,
    input logic [ISSUE_W-1:0]       lane_issue,
    input logic [CNT_W-1:0]         issued_cnt
);
    // R3
    pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ibuf_pop & ~ibuf_valid) == '0);

    // R2
    pop_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ibuf_pop) <= ISSUE_W);

    // R10
    issued_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (issued_cnt == CNT_W'($past(issued_cnt) + $countones($past(ibuf_pop)))));

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane_chk
        // R8
        issue_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_issue[l] |=> opd_valid[l]);

        // R9
        held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (opd_valid[l] && !opd_ready[l]) |=>
                (opd_valid[l] && $stable(opd_rd[l*REG_W +: REG_W])));
    end
endmodule

bind isq_issue_stage isq_issue_stage_chk #(
    .NUM_WARPS (NUM_WARPS),
    .ISSUE_W   (ISSUE_W),
    .REG_W     (REG_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ibuf_valid (ibuf_valid),
    .ibuf_pop   (ibuf_pop),
    .opd_ready  (opd_ready),
    .opd_valid  (opd_valid),
    .opd_rd     (opd_rd),
    .lane_issue (lane_issue),
    .issued_cnt (issued_cnt)
);

// File: tb/isq_issue_stage_tb.sv
module isq_issue_stage_tb;
    localparam int NW = 4;
    localparam int IW = 2;
    localparam int RW = 6;
    localparam int CW = 16;
    localparam int WW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NW-1:0]   ibuf_valid = '0, ibuf_wb = '0;
    logic [NW*2-1:0] ibuf_unit = '0;
    logic [NW*RW-1:0] ibuf_rd = '0, ibuf_rs1 = '0, ibuf_rs2 = '0;
    logic [NW-1:0]   ibuf_pop;
    logic [IW-1:0]   opd_ready = '1;
    logic [IW-1:0]   opd_valid, opd_wb;
    logic [IW*WW-1:0] opd_warp;
    logic [IW*2-1:0] opd_unit;
    logic [IW*RW-1:0] opd_rd, opd_rs1, opd_rs2;
    logic            cmt_valid = 1'b0, cmt_wb = 1'b0, cmt_eop = 1'b0;
    logic [WW-1:0]   cmt_warp = '0;
    logic [RW-1:0]   cmt_rd = '0;
    logic [CW-1:0]   stall_total, issued_cnt, committed_cnt;
    logic [4*CW-1:0] stall_unit;
    logic            core_busy;

    int n_chk = 0, n_fail = 0;
    int exp_iss = 0, exp_cmt = 0;
    int mb = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    isq_issue_stage #(.NUM_WARPS(NW), .ISSUE_W(IW), .REG_W(RW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ibuf_valid(ibuf_valid), .ibuf_wb(ibuf_wb), .ibuf_unit(ibuf_unit),
        .ibuf_rd(ibuf_rd), .ibuf_rs1(ibuf_rs1), .ibuf_rs2(ibuf_rs2), .ibuf_pop(ibuf_pop),
        .opd_ready(opd_ready), .opd_valid(opd_valid), .opd_warp(opd_warp), .opd_wb(opd_wb),
        .opd_unit(opd_unit), .opd_rd(opd_rd), .opd_rs1(opd_rs1), .opd_rs2(opd_rs2),
        .cmt_valid(cmt_valid), .cmt_warp(cmt_warp), .cmt_rd(cmt_rd), .cmt_wb(cmt_wb),
        .cmt_eop(cmt_eop), .stall_total(stall_total), .stall_unit(stall_unit),
        .issued_cnt(issued_cnt), .committed_cnt(committed_cnt), .core_busy(core_busy)
    );

    // Expected base: 0 at reset, +ISSUE_W mod NUM_WARPS every clock (R2).
    always @(posedge clk or negedge rst_n)
        if (!rst_n) mb <= 0;
        else        mb <= (mb + IW) % NW;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int su(int u);
        return int'(stall_unit[u*CW +: CW]);
    endfunction

    task automatic clear_heads();
        ibuf_valid = '0; ibuf_wb = '0; ibuf_unit = '0;
        ibuf_rd = '0; ibuf_rs1 = '0; ibuf_rs2 = '0;
    endtask

    task automatic put(int w, bit wb, int unit, int rd, int rs1, int rs2);
        ibuf_valid[w] = 1'b1;
        ibuf_wb[w] = wb;
        ibuf_unit[w*2 +: 2] = 2'(unit);
        ibuf_rd[w*RW +: RW] = RW'(rd);
        ibuf_rs1[w*RW +: RW] = RW'(rs1);
        ibuf_rs2[w*RW +: RW] = RW'(rs2);
    endtask

    task automatic tick();
        #1;
        exp_iss += $countones(ibuf_pop);
        if (cmt_valid && cmt_eop) exp_cmt++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sync_base(int b);
        clear_heads();
        while (mb != b) tick();
    endtask

    task automatic check_pop(int exp, string req);
        #1;
        check(ibuf_pop == NW'(exp), req, int'(ibuf_pop), exp);
    endtask

    task automatic t_reset();
        check(opd_valid == '0, "R1 opd_valid", int'(opd_valid), 0);
        check(issued_cnt == 0 && committed_cnt == 0, "R1 counts", int'(issued_cnt), 0);
        check(stall_total == 0 && stall_unit == '0, "R1 stalls", int'(stall_total), 0);
        check(core_busy == 1'b0, "R1 busy", int'(core_busy), 0);
    endtask

    task automatic t_rotate();
        clear_heads();
        for (int w = 0; w < NW; w++) put(w, 1'b0, 0, w + 1, 0, 0);
        for (int k = 0; k < 2; k++) begin
            int b = mb;
            check_pop((1 << b) | (1 << ((b + 1) % NW)), "R2 examined buffers");
            tick();
            check(opd_valid == 2'b11, "R8 both lanes valid", int'(opd_valid), 3);
            check(int'(opd_warp[1:0]) == b, "R8 lane0 warp", int'(opd_warp[1:0]), b);
            check(int'(opd_warp[3:2]) == (b + 1) % NW, "R8 lane1 warp",
                  int'(opd_warp[3:2]), (b + 1) % NW);
            check(int'(opd_rd[RW-1:0]) == b + 1, "R8 lane0 rd", int'(opd_rd[RW-1:0]), b + 1);
        end
        check(int'(issued_cnt) == exp_iss, "R10 issued", int'(issued_cnt), exp_iss);
    endtask

    task automatic t_empty();
        int b = mb;
        clear_heads();
        put((b + 1) % NW, 1'b0, 0, 7, 0, 0);
        check_pop(1 << ((b + 1) % NW), "R3 empty lane idle");
        tick();
        check(opd_valid == 2'b10, "R3 only lane1 valid", int'(opd_valid), 2);
    endtask

    task automatic t_hazard();
        int st, f, a, l, s;
        sync_base(0);
        put(0, 1'b1, 1, 5, 1, 2);        // reserve w0 r5 as FPU
        put(1, 1'b0, 0, 20, 3, 4);       // no writeback: r20 stays free
        check_pop(4'b0011, "R6 both issue");
        tick();
        sync_base(0);
        st = stall_total; f = su(1); a = su(0);
        put(0, 1'b1, 0, 9, 5, 5);        // hits r5 twice
        put(1, 1'b0, 0, 21, 20, 5);      // other warp, r20 unreserved
        check_pop(4'b0010, "R4/R6/R11 lane0 blocked lane1 issues");
        tick();
        check(int'(stall_total) == st + 1, "R4 stall_total", int'(stall_total), st + 1);
        check(su(1) == f + 1, "R5 fpu dedupe", su(1), f + 1);
        check(su(0) == a, "R5 alu untouched", su(0), a);
        check(opd_valid == 2'b10, "R4 lane0 no issue", int'(opd_valid), 2);
        sync_base(0);
        put(0, 1'b0, 0, 38, 37, 0);      // fp r5 does not collide with int r5
        check_pop(4'b0001, "R11 fp vs int");
        tick();
        sync_base(2);
        put(2, 1'b1, 2, 10, 0, 0);
        tick();
        sync_base(2);
        put(2, 1'b1, 3, 11, 0, 0);
        tick();
        sync_base(2);
        st = stall_total; l = su(2); s = su(3); f = su(1);
        put(2, 1'b0, 0, 10, 10, 11);
        check_pop(4'b0000, "R4 multi conflict");
        tick();
        check(int'(stall_total) == st + 1, "R4 one lane stall", int'(stall_total), st + 1);
        check(su(2) == l + 1, "R5 lsu", su(2), l + 1);
        check(su(3) == s + 1, "R5 sfu", su(3), s + 1);
        check(su(1) == f, "R5 fpu unchanged", su(1), f);
    endtask

    task automatic commit(bit wb, bit eop);
        clear_heads();
        cmt_valid = 1'b1; cmt_warp = 2'd0; cmt_rd = 6'd5; cmt_wb = wb; cmt_eop = eop;
        tick();
        cmt_valid = 1'b0; cmt_wb = 1'b0; cmt_eop = 1'b0;
    endtask

    task automatic t_release();
        commit(1'b1, 1'b0);
        sync_base(0);
        put(0, 1'b0, 0, 12, 5, 0);
        check_pop(4'b0000, "R7 wb without eop keeps pending");
        commit(1'b0, 1'b1);
        sync_base(0);
        put(0, 1'b0, 0, 12, 5, 0);
        check_pop(4'b0000, "R7 eop without wb keeps pending");
        commit(1'b1, 1'b1);
        sync_base(0);
        put(0, 1'b0, 0, 12, 5, 0);
        check_pop(4'b0001, "R7 full release");
        tick();
        check(int'(committed_cnt) == exp_cmt, "R10 committed", int'(committed_cnt), exp_cmt);
    endtask

    task automatic t_backpressure();
        int st;
        sync_base(0);
        opd_ready = 2'b00;
        put(0, 1'b0, 0, 30, 0, 0);
        check_pop(4'b0001, "R9 free lane issues");
        tick();
        sync_base(0);
        st = stall_total;
        put(0, 1'b0, 0, 31, 0, 0);
        check_pop(4'b0000, "R9 held lane no pop");
        tick();
        check(opd_valid[0] == 1'b1, "R9 entry held", int'(opd_valid[0]), 1);
        check(int'(opd_rd[RW-1:0]) == 30, "R9 payload held", int'(opd_rd[RW-1:0]), 30);
        check(int'(stall_total) == st, "R9 no stall count", int'(stall_total), st);
        clear_heads();
        opd_ready = 2'b11;
        tick();
        check(opd_valid == 2'b00, "R9 drained", int'(opd_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rotate();
        t_empty();
        t_hazard();
        t_release();
        t_backpressure();
        check(int'(issued_cnt) == exp_iss, "R10 issued final", int'(issued_cnt), exp_iss);
        check(core_busy == (exp_iss != exp_cmt), "R10 busy", int'(core_busy),
              int'(exp_iss != exp_cmt));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule